// File: doc/BRIEF.md
# Indirect Memory Addressing Unit

This block keeps three 16-bit data-memory pointers and turns CPU accesses to a small group of virtual registers into real memory cycles. Each pointer has five access registers. Plain access uses the pointer as it is. Post-increment and post-decrement use the pointer and then step it. Pre-increment steps the pointer first and then uses the new value. Offset access adds the working register to the pointer and leaves the pointer as it was. Each pointer is also visible as two byte-wide registers, so software can load it and read it back directly.

The CPU reaches the block through a byte-wide register port addressed by a 12-bit register number in the window 0xF60–0xFFF. Register 0xFE8 reflects the working register. On the memory side the block drives a 16-bit address, write data and read/write strobes to a synchronous RAM whose read data arrives one clock later. The pointer update happens in the same clock edge as the memory access.

Top module: `indirect_addr_unit`

## Requirements
- R1: After reset every pointer is 0x0000, `sfr_rdata` is 0x00 and no memory strobe is active.
- R2: Pointer n (n = 0, 1, 2) owns the register slot starting at 0xFC0 + 8·n. Slot offset 5 is the pointer's low byte and offset 6 is its high byte. Both can be written, and a read returns the byte on `sfr_rdata` one cycle after the read request.
- R3: An access at slot offset 0 (plain) uses the pointer as the memory address and leaves the pointer unchanged.
- R4: An access at slot offset 1 (post-increment) uses the current pointer as the address. The pointer is one greater from the next cycle on.
- R5: An access at slot offset 2 (post-decrement) uses the current pointer as the address. The pointer is one less from the next cycle on.
- R6: An access at slot offset 3 (pre-increment) uses the pointer plus one as the address, and the pointer keeps that new value.
- R7: An access at slot offset 4 (offset) uses the pointer plus `w_val` as the address, with `w_val` zero-extended. The pointer is unchanged.
- R8: Increment, decrement and offset addition all wrap modulo 2^16.
- R9: An indirect read raises `mem_re` in the request cycle, and `sfr_rdata` equals the RAM data in the next cycle. An indirect write raises `mem_we` with `mem_wdata` equal to `sfr_wdata` in the same cycle. The two strobes are never active together, and neither is active without a CPU request.
- R10: If the address an indirect access would use equals one of the indirect access registers (slot offsets 0–4 of any pointer, upper address nibble zero), the access raises no strobe and leaves the pointer unchanged. A read then returns 0x00 and a write is discarded.
- R11: A read of 0xFE8 returns `w_val`. A read of any other unmapped register returns 0x00. Writes to 0xFE8 or to unmapped registers raise no strobe and change no pointer.
- R12: An access through one pointer's registers never changes either of the other pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 12 | Register number of the CPU access |
| sfr_re | input | 1 | CPU read request |
| sfr_we | input | 1 | CPU write request (wins over a read) |
| sfr_wdata | input | 8 | CPU write data |
| sfr_rdata | output | 8 | Read data, valid the cycle after `sfr_re` |
| w_val | input | 8 | Working register value |
| mem_addr | output | 16 | Data-memory address |
| mem_re | output | 1 | Data-memory read strobe |
| mem_we | output | 1 | Data-memory write strobe |
| mem_wdata | output | 8 | Data-memory write data |
| mem_rdata | input | 8 | Registered data-memory read data |

## Verification
The assertions check on every cycle that the two memory strobes are exclusive and always caused by a CPU request. They also check that plain, offset and self-referencing accesses leave all pointers stable, that register 0xFE8 and self-referencing addresses never reach memory, and that no pointer changes unless its own registers were touched. Only the bench's scenarios show the actual arithmetic. That covers the exact addresses produced in each mode, the values the pointers hold after increments, decrements and wrap-around, and the order of address generation and update in pre-increment access. It also covers read data arriving on the following cycle and the values read back through the byte registers.

// File: rtl/iau_pkg.sv
package iau_pkg;

    localparam int unsigned SFR_AW  = 12;
    localparam int unsigned SLOT_LG = 3;
    localparam int unsigned N_MODES = 5;

    localparam logic [SLOT_LG-1:0] OFF_LO = 3'd5;
    localparam logic [SLOT_LG-1:0] OFF_HI = 3'd6;

    typedef enum logic [SLOT_LG-1:0] {
        AM_PLAIN   = 3'd0,
        AM_POSTINC = 3'd1,
        AM_POSTDEC = 3'd2,
        AM_PREINC  = 3'd3,
        AM_PLUSW   = 3'd4
    } amode_e;

    // Index of the pointer slot a register number falls in (wraps below base)
    function automatic logic [SFR_AW-SLOT_LG-1:0] blk_index(
        input logic [SFR_AW-1:0] a,
        input logic [SFR_AW-1:0] base
    );
        return a[SFR_AW-1:SLOT_LG] - base[SFR_AW-1:SLOT_LG];
    endfunction

    // True when a register number is one of the indirect access registers
    function automatic logic is_ind(
        input logic [SFR_AW-1:0] a,
        input logic [SFR_AW-1:0] base,
        input int unsigned       nblk
    );
        return (32'(blk_index(a, base)) < nblk) && (32'(a[SLOT_LG-1:0]) < N_MODES);
    endfunction

endpackage

// File: rtl/iau_decode.sv
module iau_decode
    import iau_pkg::*;
#(
    parameter int unsigned        NPTR      = 3,
    parameter int unsigned        SEL_W     = 2,
    parameter logic [SFR_AW-1:0]  IND_BASE  = 12'hFC0,
    parameter logic [SFR_AW-1:0]  WREG_ADDR = 12'hFE8
) (
    input  logic [SFR_AW-1:0] addr,
    output logic              ind_hit,
    output logic              lo_hit,
    output logic              hi_hit,
    output logic              wreg_hit,
    output logic [SEL_W-1:0]  sel,
    output amode_e            mode
);

    logic [SFR_AW-SLOT_LG-1:0] blk;
    logic                      in_range;
    logic [SLOT_LG-1:0]        off;

    assign blk      = blk_index(addr, IND_BASE);
    assign in_range = 32'(blk) < NPTR;
    assign off      = addr[SLOT_LG-1:0];

    assign sel      = SEL_W'(blk);
    assign ind_hit  = is_ind(addr, IND_BASE, NPTR);
    assign lo_hit   = in_range && (off == OFF_LO);
    assign hi_hit   = in_range && (off == OFF_HI);
    assign wreg_hit = (addr == WREG_ADDR);
    assign mode     = ind_hit ? amode_e'(off) : AM_PLAIN;

endmodule

// File: rtl/iau_agen.sv
module iau_agen
    import iau_pkg::*;
#(
    parameter int unsigned PTR_W = 16,
    parameter int unsigned DAT_W = 8
) (
    input  logic [PTR_W-1:0] ptr,
    input  amode_e           mode,
    input  logic [DAT_W-1:0] woff,
    output logic [PTR_W-1:0] ea,
    output logic [PTR_W-1:0] nxt
);

    logic [PTR_W-1:0] inc;
    logic [PTR_W-1:0] dec;

    always_comb begin
        inc = ptr + PTR_W'(1);
        dec = ptr - PTR_W'(1);
        ea  = ptr;
        nxt = ptr;
        case (mode)
            AM_POSTINC: nxt = inc;
            AM_POSTDEC: nxt = dec;
            AM_PREINC: begin
                ea  = inc;
                nxt = inc;
            end
            AM_PLUSW:   ea = ptr + PTR_W'(woff);
            default: ;
        endcase
    end

endmodule

// File: rtl/iau_ptrs.sv
module iau_ptrs #(
    parameter int unsigned NPTR  = 3,
    parameter int unsigned PTR_W = 16,
    parameter int unsigned DAT_W = 8,
    parameter int unsigned SEL_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd_en,
    input  logic [SEL_W-1:0]            upd_sel,
    input  logic [PTR_W-1:0]            upd_val,
    input  logic                        wr_lo,
    input  logic                        wr_hi,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [DAT_W-1:0]            wr_byte,
    output logic [NPTR-1:0][PTR_W-1:0]  ptrs
);

    localparam int unsigned HI_W = PTR_W - DAT_W;

    typedef struct packed {
        logic [NPTR-1:0][PTR_W-1:0] ptr;
    } pstate_t;

    pstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NPTR; i++) begin
            if (upd_en && upd_sel == SEL_W'(i)) st_d.ptr[i] = upd_val;
            // direct byte loads override an auto-update
            if (wr_lo && wr_sel == SEL_W'(i)) st_d.ptr[i][DAT_W-1:0] = wr_byte;
            if (wr_hi && wr_sel == SEL_W'(i)) st_d.ptr[i][PTR_W-1:DAT_W] = wr_byte[HI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar n = 0; n < NPTR; n++) begin : g_ptr
        assign ptrs[n] = st_q.ptr[n];

        // R12: a pointer only moves when its own registers are addressed
        p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (!(upd_en && upd_sel == SEL_W'(n)) && !((wr_lo || wr_hi) && wr_sel == SEL_W'(n)))
            |=> $stable(st_q.ptr[n]));
    end

endmodule

// File: rtl/indirect_addr_unit.sv
module indirect_addr_unit
    import iau_pkg::*;
#(
    parameter int unsigned       NPTR      = 3,
    parameter int unsigned       PTR_W     = 16,
    parameter int unsigned       DAT_W     = 8,
    parameter logic [SFR_AW-1:0] IND_BASE  = 12'hFC0,
    parameter logic [SFR_AW-1:0] WREG_ADDR = 12'hFE8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SFR_AW-1:0] sfr_addr,
    input  logic              sfr_re,
    input  logic              sfr_we,
    input  logic [DAT_W-1:0]  sfr_wdata,
    output logic [DAT_W-1:0]  sfr_rdata,
    input  logic [DAT_W-1:0]  w_val,
    output logic [PTR_W-1:0]  mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DAT_W-1:0]  mem_wdata,
    input  logic [DAT_W-1:0]  mem_rdata
);

    localparam int unsigned SEL_W = (NPTR > 1) ? $clog2(NPTR) : 1;

    typedef struct packed {
        logic             from_mem;
        logic [DAT_W-1:0] hold;
    } rd_t;

    logic                       acc, is_rd, is_wr;
    logic                       cpu_ind, cpu_lo, cpu_hi, cpu_wreg;
    logic [SEL_W-1:0]           cpu_sel;
    amode_e                     cpu_mode;
    logic [NPTR-1:0][PTR_W-1:0] ptrs;
    logic [PTR_W-1:0]           cur_ptr, ea, nxt;
    logic                       self_ref, go;
    rd_t                        rd_d, rd_q;

    assign acc   = sfr_re | sfr_we;
    assign is_wr = sfr_we;
    assign is_rd = sfr_re & ~sfr_we;

    iau_decode #(
        .NPTR(NPTR), .SEL_W(SEL_W), .IND_BASE(IND_BASE), .WREG_ADDR(WREG_ADDR)
    ) u_dec (
        .addr(sfr_addr), .ind_hit(cpu_ind), .lo_hit(cpu_lo), .hi_hit(cpu_hi),
        .wreg_hit(cpu_wreg), .sel(cpu_sel), .mode(cpu_mode)
    );

    always_comb begin
        cur_ptr = '0;
        for (int i = 0; i < NPTR; i++)
            if (cpu_sel == SEL_W'(i)) cur_ptr = ptrs[i];
    end

    iau_agen #(.PTR_W(PTR_W), .DAT_W(DAT_W)) u_agen (
        .ptr(cur_ptr), .mode(cpu_mode), .woff(w_val), .ea(ea), .nxt(nxt)
    );

    // effective address landing on an indirect register itself
    assign self_ref = (ea[PTR_W-1:SFR_AW] == '0) && is_ind(ea[SFR_AW-1:0], IND_BASE, NPTR);
    assign go       = acc && cpu_ind && !self_ref;

    assign mem_addr  = ea;
    assign mem_re    = go && is_rd;
    assign mem_we    = go && is_wr;
    assign mem_wdata = sfr_wdata;

    iau_ptrs #(.NPTR(NPTR), .PTR_W(PTR_W), .DAT_W(DAT_W), .SEL_W(SEL_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n),
        .upd_en(go), .upd_sel(cpu_sel), .upd_val(nxt),
        .wr_lo(is_wr && cpu_lo), .wr_hi(is_wr && cpu_hi),
        .wr_sel(cpu_sel), .wr_byte(sfr_wdata),
        .ptrs(ptrs)
    );

    always_comb begin
        rd_d.from_mem = is_rd && go;
        rd_d.hold     = '0;
        if (is_rd) begin
            if (cpu_lo)        rd_d.hold = cur_ptr[DAT_W-1:0];
            else if (cpu_hi)   rd_d.hold = DAT_W'(cur_ptr[PTR_W-1:DAT_W]);
            else if (cpu_wreg) rd_d.hold = w_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign sfr_rdata = rd_q.from_mem ? mem_rdata : rd_q.hold;

    // R9: strobes exclusive and only in response to a CPU request
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
    p_strobe_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> (sfr_re || sfr_we));

    // R3: plain access keeps every pointer
    p_keep_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cpu_ind && cpu_mode == AM_PLAIN) |=> $stable(ptrs));

    // R7: offset access keeps every pointer
    p_keep_plusw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cpu_ind && cpu_mode == AM_PLUSW) |=> $stable(ptrs));

    // R10: self-referencing access is silent, keeps pointers, reads zero
    p_self_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ind && self_ref) |-> (!mem_re && !mem_we));
    p_self_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cpu_ind && self_ref) |=> $stable(ptrs));
    p_self_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && cpu_ind && self_ref) |=> (sfr_rdata == '0));

    // R11: working-register address never reaches memory
    p_wreg_nomem_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wreg |-> (!mem_re && !mem_we));

endmodule

// File: tb/indirect_addr_unit_test.sv
module indirect_addr_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] sfr_addr = '0;
    logic        sfr_re = 1'b0, sfr_we = 1'b0;
    logic [7:0]  sfr_wdata = '0, w_val = '0;
    logic [7:0]  sfr_rdata;
    logic [15:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    indirect_addr_unit uut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_re(sfr_re),
        .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .w_val(w_val), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] patt(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // RAM model: registered read of an address-derived pattern
    always_ff @(posedge clk)
        if (mem_re) mem_rdata <= patt(mem_addr);

    task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    // entry: req(4) rd(1) addr(12) wdata(8) w(8) mem-kind(2: 0 none,1 read,2 write) addr(16) rdata(8)
    localparam int NV = 41;
    localparam logic [58:0] VEC [NV] = '{
        {4'd2,  1'b0, 12'hFC5, 8'h34, 8'h00, 2'd0, 16'h0000, 8'h00}, // R2 load p0 lo
        {4'd2,  1'b0, 12'hFC6, 8'h12, 8'h00, 2'd0, 16'h0000, 8'h00}, // R2 load p0 hi
        {4'd2,  1'b1, 12'hFC5, 8'h00, 8'h00, 2'd0, 16'h0000, 8'h34},
        {4'd2,  1'b1, 12'hFC6, 8'h00, 8'h00, 2'd0, 16'h0000, 8'h12},
        {4'd3,  1'b1, 12'hFC0, 8'h00, 8'h00, 2'd1, 16'h1234, 8'h00}, // R3 plain
        {4'd4,  1'b1, 12'hFC1, 8'h00, 8'h00, 2'd1, 16'h1234, 8'h00}, // R4 postinc
        {4'd4,  1'b1, 12'hFC1, 8'h00, 8'h00, 2'd1, 16'h1235, 8'h00},
        {4'd5,  1'b0, 12'hFC2, 8'h77, 8'h00, 2'd2, 16'h1236, 8'h00}, // R5 postdec write
        {4'd6,  1'b1, 12'hFC3, 8'h00, 8'h00, 2'd1, 16'h1236, 8'h00}, // R6 preinc
        {4'd7,  1'b1, 12'hFC4, 8'h00, 8'hF0, 2'd1, 16'h1326, 8'h00}, // R7 offset
        {4'd7,  1'b1, 12'hFC5, 8'h00, 8'h00, 2'd0, 16'h0000, 8'h36},
        {4'd2,  1'b0, 12'hFCD, 8'hFF, 8'h00, 2'd0, 16'h0000, 8'h00},
        {4'd2,  1'b0, 12'hFCE, 8'hFF, 8'h00, 2'd0, 16'h0000, 8'h00},
        {4'd8,  1'b1, 12'hFC9, 8'h00, 8'h00, 2'd1, 16'hFFFF, 8'h00}, // R8 wrap up
        {4'd8,  1'b1, 12'hFCD, 8'h00, 8'h00, 2'd0, 16'h0000, 8'h00},
        {4'd8,  1'b1, 12'hFCE, 8'h00, 8'h00, 2'd0, 16'h0000, 8'h00},
        {4'd8,  1'b1, 12'hFCA, 8'h00, 8'h00, 2'd1, 16'h0000, 8'h00}, // R8 wrap down
        {4'd8,  1'b1, 12'hFCE, 8'h00, 8'h00, 2'd0, 16'h0000, 8'hFF},
        {4'd8,  1'b1, 12'hFCD, 8'h00, 8'h00, 2'd0, 16'h0000, 8'hFF},
        {4'd12, 1'b1, 12'hFC5, 8'h00, 8'h00, 2'd0, 16'h0000, 8'h36}, // R12 p0 untouched
        {4'd12, 1'b1, 12'hFC6, 8'h00, 8'h00, 2'd0, 16'h0000, 8'h12},
        {4'd2,  1'b0, 12'hFD5, 8'hC0, 8'h00, 2'd0, 16'h0000, 8'h00},
        {4'd2,  1'b0, 12'hFD6, 8'h0F, 8'h00, 2'd0, 16'h0000, 8'h00},
        {4'd10, 1'b1, 12'hFD0, 8'h00, 8'h00, 2'd0, 16'h0000, 8'h00}, // R10 self plain
        {4'd10, 1'b1, 12'hFD1, 8'h00, 8'h00, 2'd0, 16'h0000, 8'h00}, // R10 self postinc
        {4'd10, 1'b1, 12'hFD5, 8'h00, 8'h00, 2'd0, 16'h0000, 8'hC0},
        {4'd10, 1'b0, 12'hFD2, 8'h55, 8'h00, 2'd0, 16'h0000, 8'h00}, // R10 self write
        {4'd10, 1'b1, 12'hFD5, 8'h00, 8'h00, 2'd0, 16'h0000, 8'hC0},
        {4'd10, 1'b1, 12'hFD4, 8'h00, 8'h08, 2'd0, 16'h0000, 8'h00}, // R10 offset onto p1 plain
        {4'd7,  1'b1, 12'hFD4, 8'h00, 8'h07, 2'd1, 16'h0FC7, 8'h00}, // R7 offset to unused slot
        {4'd2,  1'b0, 12'hFD5, 8'hBF, 8'h00, 2'd0, 16'h0000, 8'h00},
        {4'd10, 1'b1, 12'hFD3, 8'h00, 8'h00, 2'd0, 16'h0000, 8'h00}, // R10 preinc onto 0FC0
        {4'd10, 1'b1, 12'hFD5, 8'h00, 8'h00, 2'd0, 16'h0000, 8'hBF},
        {4'd11, 1'b1, 12'hFE8, 8'h00, 8'h9C, 2'd0, 16'h0000, 8'h9C}, // R11 working reg
        {4'd11, 1'b0, 12'hFE8, 8'h11, 8'h00, 2'd0, 16'h0000, 8'h00},
        {4'd11, 1'b1, 12'hF70, 8'h00, 8'h00, 2'd0, 16'h0000, 8'h00},
        {4'd11, 1'b1, 12'hFD6, 8'h00, 8'h00, 2'd0, 16'h0000, 8'h0F},
        {4'd9,  1'b0, 12'hFC4, 8'hAA, 8'h10, 2'd2, 16'h1246, 8'h00}, // R9 offset write
        {4'd9,  1'b1, 12'hFC5, 8'h00, 8'h00, 2'd0, 16'h0000, 8'h36},
        {4'd6,  1'b0, 12'hFC3, 8'hBB, 8'h00, 2'd2, 16'h1237, 8'h00}, // R6 preinc write
        {4'd6,  1'b1, 12'hFC5, 8'h00, 8'h00, 2'd0, 16'h0000, 8'h37}
    };

    task automatic access(input bit rd, input logic [11:0] a, input logic [7:0] wd,
                          input logic [7:0] w, output logic [7:0] got);
        @(negedge clk);
        sfr_addr = a; sfr_re = rd; sfr_we = !rd; sfr_wdata = wd; w_val = w;
        @(posedge clk);
        @(negedge clk);
        sfr_re = 1'b0; sfr_we = 1'b0;
        got = sfr_rdata;
    endtask

    task automatic run_vec(input logic [58:0] v);
        int          req = int'(v[58:55]);
        bit          rd  = v[54];
        logic [1:0]  kind = v[25:24];
        logic [15:0] ea = v[23:8];
        logic [7:0]  exp;
        @(negedge clk);
        sfr_addr = v[53:42]; sfr_re = rd; sfr_we = !rd;
        sfr_wdata = v[41:34]; w_val = v[33:26];
        #1;
        case (kind)
            2'd0: check(!mem_re && !mem_we, req, {30'd0, mem_re, mem_we}, 32'd0);
            2'd1: check(mem_re && !mem_we && mem_addr == ea, req, {mem_re, mem_we, 14'd0, mem_addr}, {2'b10, 14'd0, ea});
            default: check(mem_we && !mem_re && mem_addr == ea && mem_wdata == v[41:34], req,
                           {mem_wdata, 6'd0, mem_re, mem_we, mem_addr}, {v[41:34], 6'd0, 2'b01, ea});
        endcase
        @(posedge clk);
        @(negedge clk);
        sfr_re = 1'b0; sfr_we = 1'b0;
        if (rd) begin
            exp = (kind == 2'd1) ? patt(ea) : v[7:0];
            check(sfr_rdata == exp, req, {24'd0, sfr_rdata}, {24'd0, exp});
        end
    endtask

    initial begin
        logic [7:0] got;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check(sfr_rdata == 8'h00 && !mem_re && !mem_we, 1, {22'd0, mem_re, mem_we, sfr_rdata}, 32'd0);
        rst_n = 1'b1;
        for (int a = 0; a < 3; a++) begin
            access(1'b1, 12'hFC5 + 12'(8 * a), 8'h00, 8'h00, got);
            check(got == 8'h00, 1, {24'd0, got}, 32'd0); // R1 low bytes zero
            access(1'b1, 12'hFC6 + 12'(8 * a), 8'h00, 8'h00, got);
            check(got == 8'h00, 1, {24'd0, got}, 32'd0); // R1 high bytes zero
        end
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R1: reset in mid-run clears loaded pointers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(sfr_rdata == 8'h00, 1, {24'd0, sfr_rdata}, 32'd0);
        rst_n = 1'b1;
        access(1'b1, 12'hFC5, 8'h00, 8'h00, got);
        check(got == 8'h00, 1, {24'd0, got}, 32'd0);
        access(1'b1, 12'hFCE, 8'h00, 8'h00, got);
        check(got == 8'h00, 1, {24'd0, got}, 32'd0);

        // R4/R5: step p2 up twice then down once, read back
        access(1'b0, 12'hFD1, 8'h01, 8'h00, got);
        access(1'b0, 12'hFD1, 8'h02, 8'h00, got);
        access(1'b1, 12'hFD2, 8'h00, 8'h00, got);
        check(got == patt(16'h0002), 5, {24'd0, got}, {24'd0, patt(16'h0002)});
        access(1'b1, 12'hFD5, 8'h00, 8'h00, got);
        check(got == 8'h01, 4, {24'd0, got}, 32'd1);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule